// File: doc/BRIEF.md
# I2C Master Acknowledge and Stop Sequencer

This block is the line-sequencing stage of an I2C master. After a byte has been received, it drives the acknowledge bit onto the bus. At the end of a transfer, it generates a Stop condition. Every timed phase is measured by a reloadable down-counter. The counter is loaded from `baud_reload_i`, so a reload value of N gives a phase of N+1 clock cycles. Phases that release a line do not start their timing until the sampled line has actually gone high. A slave that stretches SCL therefore lengthens the sequence, and nothing is cut short.

SCL and SDA are modelled as open-drain pull-low enables, with separate sampled inputs. The surrounding controller requests a sequence with a one-cycle pulse. It reads the busy bits, the sticky interrupt and stop-detected flags, and the collision flag. Any write to the data buffer while a sequence is running is refused, and the collision flag records it.

Top module: `i2c_ack_stop_seq`

## Requirements
- R1: An `ack_req_i` pulse accepted in idle makes `ack_busy_o` high in the next cycle. In that same cycle `scl_pull_o` is 1 and `sda_pull_o` equals the inverse of `ack_data_i` (0 drives ACK, 1 leaves SDA released), and SDA stays at that value for the whole sequence.
- R2: During the acknowledge sequence, SCL stays pulled for N+1 cycles and is then released, where N is `baud_reload_i`.
- R3: The acknowledge high phase starts only in the cycle after `scl_i` is sampled high, so extra low cycles from a stretching slave add directly to the sequence. After N+1 cycles of high phase, SCL is pulled low again.
- R4: At the end of the acknowledge sequence, `ack_busy_o` drops, `irq_o` is set and SDA is released. SCL remains pulled low while the block is idle.
- R5: A `stop_req_i` pulse accepted in idle pulls both SDA and SCL in the next cycle. In the cycle after `sda_i` is sampled low, the counter starts, and after N+1 cycles SCL is released.
- R6: In the cycle after `scl_i` is sampled high, a new N+1 cycle period starts. SDA is released at its end, and only while SCL is released.
- R7: `stop_det_o` is set in the cycle after both `scl_i` and `sda_i` are sampled high. N+1 cycles later, `stop_busy_o` drops, `irq_o` is set and both lines are released.
- R8: A `buf_wr_i` strobe while either busy bit is high sets `wcol_o` and leaves `buf_q_o` unchanged. A strobe in idle loads `buf_wdata_i` into `buf_q_o`.
- R9: `irq_o`, `wcol_o` and `stop_det_o` are sticky and clear on `flag_clr_i`. `stop_det_o` also clears when a new sequence starts.
- R10: If both requests arrive in the same idle cycle, the acknowledge sequence runs and the Stop request is dropped. Any request that arrives while a sequence is busy is ignored.
- R11: After reset, both pull enables, all flags and both busy bits are 0, and `buf_q_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ack_req_i | input | 1 | Start acknowledge sequence (pulse) |
| ack_data_i | input | 1 | Acknowledge bit value, 0 = ACK, 1 = NACK |
| stop_req_i | input | 1 | Start Stop sequence (pulse) |
| flag_clr_i | input | 1 | Clear irq, collision and stop-detected flags |
| baud_reload_i | input | BAUD_W | Counter reload value N (phase = N+1 cycles) |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| buf_wr_i | input | 1 | Data buffer write strobe |
| buf_wdata_i | input | DATA_W | Data buffer write value |
| scl_pull_o | output | 1 | Pull SCL low |
| sda_pull_o | output | 1 | Pull SDA low |
| ack_busy_o | output | 1 | Acknowledge sequence running |
| stop_busy_o | output | 1 | Stop sequence running |
| irq_o | output | 1 | Sequence-complete interrupt flag |
| stop_det_o | output | 1 | Stop condition seen on the bus |
| wcol_o | output | 1 | Write-collision flag |
| buf_q_o | output | DATA_W | Data buffer contents |

## Verification
The bench builds the block with a 6-bit reload width and an 8-bit buffer. With that width, the reload values 0, 1, 2, 3, 5 and 40 can be used, from the shortest phase of one cycle to long ones, while the run stays short. A wired-AND bus model holds SCL low for 0 to 4 extra cycles, which lets the bench check that the stretch adds cycle for cycle to both the acknowledge and the Stop timing. The scoreboard predicts the exact cycle of every pull-enable edge, so any wrong phase length shows up as an early or late event.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACK_LOW,
    ST_ACK_WAIT,
    ST_ACK_HIGH,
    ST_STP_SDA,
    ST_STP_LOW,
    ST_STP_WAIT,
    ST_STP_HIGH,
    ST_STP_SDAW,
    ST_STP_TAIL
  } seq_state_e;
endpackage

// File: rtl/i2c_baud_cnt.sv
module i2c_baud_cnt #(
  parameter int BAUD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [BAUD_W-1:0] reload_i,
  output logic              tick_o
);
  logic [BAUD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= reload_i;
    else if (run_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = run_i && (cnt_q == '0);

  // counter only moves while a timed phase runs
  AST_CNT_HOLDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(run_i) && !$past(load_i)) |-> $stable(cnt_q)); // R2
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_req_i,
  input  logic ack_data_i,
  input  logic stop_req_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic tick_i,
  output logic load_o,
  output logic run_o,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic ack_busy_o,
  output logic stop_busy_o,
  output logic start_o,
  output logic done_o,
  output logic stop_seen_o
);
  seq_state_e state_q, state_d;
  logic       dt_q;
  logic       scl_hold_q;

  always_comb begin
    state_d     = state_q;
    load_o      = 1'b0;
    start_o     = 1'b0;
    done_o      = 1'b0;
    stop_seen_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ack_req_i) begin
          state_d = ST_ACK_LOW;
          load_o  = 1'b1;
          start_o = 1'b1;
        end else if (stop_req_i) begin
          state_d = ST_STP_SDA;
          start_o = 1'b1;
        end
      end
      ST_ACK_LOW:  if (tick_i) state_d = ST_ACK_WAIT;
      ST_ACK_WAIT: if (scl_i) begin
        state_d = ST_ACK_HIGH;
        load_o  = 1'b1;
      end
      ST_ACK_HIGH: if (tick_i) begin
        state_d = ST_IDLE;
        done_o  = 1'b1;
      end
      ST_STP_SDA:  if (!sda_i) begin
        state_d = ST_STP_LOW;
        load_o  = 1'b1;
      end
      ST_STP_LOW:  if (tick_i) state_d = ST_STP_WAIT;
      ST_STP_WAIT: if (scl_i) begin
        state_d = ST_STP_HIGH;
        load_o  = 1'b1;
      end
      ST_STP_HIGH: if (tick_i) state_d = ST_STP_SDAW;
      ST_STP_SDAW: if (scl_i && sda_i) begin
        state_d     = ST_STP_TAIL;
        load_o      = 1'b1;
        stop_seen_o = 1'b1;
      end
      ST_STP_TAIL: if (tick_i) begin
        state_d = ST_IDLE;
        done_o  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      dt_q       <= 1'b1;
      scl_hold_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && ack_req_i) dt_q <= ack_data_i;
      if (done_o) scl_hold_q <= (state_q == ST_ACK_HIGH);
    end
  end

  always_comb begin
    run_o       = 1'b0;
    scl_pull_o  = 1'b0;
    sda_pull_o  = 1'b0;
    ack_busy_o  = 1'b0;
    stop_busy_o = 1'b0;
    unique case (state_q)
      ST_IDLE:     scl_pull_o = scl_hold_q;
      ST_ACK_LOW:  begin run_o = 1'b1; scl_pull_o = 1'b1; sda_pull_o = !dt_q; ack_busy_o = 1'b1; end
      ST_ACK_WAIT: begin sda_pull_o = !dt_q; ack_busy_o = 1'b1; end
      ST_ACK_HIGH: begin run_o = 1'b1; sda_pull_o = !dt_q; ack_busy_o = 1'b1; end
      ST_STP_SDA:  begin scl_pull_o = 1'b1; sda_pull_o = 1'b1; stop_busy_o = 1'b1; end
      ST_STP_LOW:  begin run_o = 1'b1; scl_pull_o = 1'b1; sda_pull_o = 1'b1; stop_busy_o = 1'b1; end
      ST_STP_WAIT: begin sda_pull_o = 1'b1; stop_busy_o = 1'b1; end
      ST_STP_HIGH: begin run_o = 1'b1; sda_pull_o = 1'b1; stop_busy_o = 1'b1; end
      ST_STP_SDAW: stop_busy_o = 1'b1;
      ST_STP_TAIL: begin run_o = 1'b1; stop_busy_o = 1'b1; end
      default: ;
    endcase
  end

  AST_ACK_SDA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_busy_o && $past(ack_busy_o)) |-> $stable(sda_pull_o)); // R1
  AST_ACK_HIGH_AFTER_SCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK_HIGH && $past(state_q) == ST_ACK_WAIT) |-> $past(scl_i)); // R3
  AST_STOP_SDA_UP_SCL_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_busy_o && $fell(sda_pull_o)) |-> !scl_pull_o); // R6
  AST_STOP_TIMER_AFTER_SDA_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STP_LOW && $past(state_q) == ST_STP_SDA) |-> !$past(sda_i)); // R5
endmodule

// File: rtl/i2c_seq_status.sv
module i2c_seq_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              buf_wr_i,
  input  logic [DATA_W-1:0] buf_wdata_i,
  input  logic              start_i,
  input  logic              done_i,
  input  logic              stop_seen_i,
  input  logic              clr_i,
  output logic              irq_o,
  output logic              stop_det_o,
  output logic              wcol_o,
  output logic [DATA_W-1:0] buf_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o      <= 1'b0;
      stop_det_o <= 1'b0;
      wcol_o     <= 1'b0;
      buf_q_o    <= '0;
    end else begin
      if (done_i)      irq_o <= 1'b1;
      else if (clr_i)  irq_o <= 1'b0;

      if (stop_seen_i)             stop_det_o <= 1'b1;
      else if (clr_i || start_i)   stop_det_o <= 1'b0;

      if (buf_wr_i && busy_i)      wcol_o <= 1'b1;
      else if (clr_i)              wcol_o <= 1'b0;

      if (buf_wr_i && !busy_i)     buf_q_o <= buf_wdata_i;
    end
  end

  AST_WCOL_KEEPS_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_wr_i && busy_i) |=> (wcol_o && $stable(buf_q_o))); // R8
  AST_IRQ_ONLY_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(done_i)); // R4
endmodule

// File: rtl/i2c_ack_stop_seq.sv
module i2c_ack_stop_seq #(
  parameter int BAUD_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ack_req_i,
  input  logic              ack_data_i,
  input  logic              stop_req_i,
  input  logic              flag_clr_i,
  input  logic [BAUD_W-1:0] baud_reload_i,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              buf_wr_i,
  input  logic [DATA_W-1:0] buf_wdata_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  output logic              ack_busy_o,
  output logic              stop_busy_o,
  output logic              irq_o,
  output logic              stop_det_o,
  output logic              wcol_o,
  output logic [DATA_W-1:0] buf_q_o
);
  logic tick, load, run, start, done, stop_seen;

  i2c_baud_cnt #(.BAUD_W(BAUD_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .run_i    (run),
    .reload_i (baud_reload_i),
    .tick_o   (tick)
  );

  i2c_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ack_req_i   (ack_req_i),
    .ack_data_i  (ack_data_i),
    .stop_req_i  (stop_req_i),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .tick_i      (tick),
    .load_o      (load),
    .run_o       (run),
    .scl_pull_o  (scl_pull_o),
    .sda_pull_o  (sda_pull_o),
    .ack_busy_o  (ack_busy_o),
    .stop_busy_o (stop_busy_o),
    .start_o     (start),
    .done_o      (done),
    .stop_seen_o (stop_seen)
  );

  i2c_seq_status #(.DATA_W(DATA_W)) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (ack_busy_o | stop_busy_o),
    .buf_wr_i    (buf_wr_i),
    .buf_wdata_i (buf_wdata_i),
    .start_i     (start),
    .done_i      (done),
    .stop_seen_i (stop_seen),
    .clr_i       (flag_clr_i),
    .irq_o       (irq_o),
    .stop_det_o  (stop_det_o),
    .wcol_o      (wcol_o),
    .buf_q_o     (buf_q_o)
  );

  AST_STOP_DET_BUS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_det_o) |-> $past(scl_i && sda_i && stop_busy_o)); // R7
  AST_SINGLE_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_busy_o) |-> $past(!ack_busy_o && !ack_req_i)); // R10
endmodule

// File: tb/i2c_ack_stop_seq_test.sv
module i2c_ack_stop_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int BAUD_W = 6;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ack_req = 1'b0, ack_dt = 1'b0, stop_req = 1'b0, flag_clr = 1'b0;
  logic [BAUD_W-1:0] reload = '0;
  logic buf_wr = 1'b0;
  logic [DATA_W-1:0] buf_wdata = '0;
  logic stretch = 1'b0;
  logic scl_in, sda_in;
  logic scl_pull, sda_pull, ack_busy, stop_busy, irq, stop_det, wcol;
  logic [DATA_W-1:0] buf_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // wired-AND bus, bench may stretch SCL
  assign scl_in = ~scl_pull & ~stretch;
  assign sda_in = ~sda_pull;

  i2c_ack_stop_seq #(.BAUD_W(BAUD_W), .DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ack_req_i(ack_req), .ack_data_i(ack_dt),
    .stop_req_i(stop_req), .flag_clr_i(flag_clr), .baud_reload_i(reload),
    .scl_i(scl_in), .sda_i(sda_in), .buf_wr_i(buf_wr), .buf_wdata_i(buf_wdata),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .ack_busy_o(ack_busy),
    .stop_busy_o(stop_busy), .irq_o(irq), .stop_det_o(stop_det), .wcol_o(wcol),
    .buf_q_o(buf_q)
  );

  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    int    cyc;
    logic  scl;
    logic  sda;
    string tag;
  } ev_t;
  ev_t exp_q[$];
  logic m_scl = 1'b0, m_sda = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(int c, logic s, logic d, string tag);
    ev_t ev;
    if (s !== m_scl || d !== m_sda) begin
      ev.cyc = c; ev.scl = s; ev.sda = d; ev.tag = tag;
      exp_q.push_back(ev);
      m_scl = s;
      m_sda = d;
    end
  endtask

  // monitor: every pin change must match the next predicted event
  logic [1:0] prev_pins = 2'b00;
  always @(negedge clk) begin
    if (rst_n) begin
      if ({scl_pull, sda_pull} !== prev_pins) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_err++;
          $display("FAIL R10 unexpected pin change at cycle %0d: actual scl=%0b sda=%0b expected none",
                   cyc, scl_pull, sda_pull);
        end else begin
          ev_t ev;
          ev = exp_q.pop_front();
          if (ev.cyc != cyc || ev.scl !== scl_pull || ev.sda !== sda_pull) begin
            n_err++;
            $display("FAIL %s: actual cyc=%0d scl=%0b sda=%0b expected cyc=%0d scl=%0b sda=%0b",
                     ev.tag, cyc, scl_pull, sda_pull, ev.cyc, ev.scl, ev.sda);
          end
        end
      end
      prev_pins = {scl_pull, sda_pull};
    end
  end

  task automatic wait_cyc(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic do_ack(logic dt, int n, int s, bit extras, bit both);
    int e;
    logic [DATA_W-1:0] keep;
    reload = BAUD_W'(n);
    ack_dt = dt;
    ack_req = 1'b1;
    stop_req = both;
    stretch = 1'b1;
    e = cyc + 1;
    push(e, 1'b1, !dt, "R1");
    push(e + n + 1, 1'b0, !dt, "R2");
    push(e + 2*n + 3 + s, 1'b1, 1'b0, "R4");
    @(negedge clk);
    ack_req = 1'b0;
    stop_req = 1'b0;
    chk("R1 ack busy", ack_busy, 1);
    chk("R10 stop not started", stop_busy, 0);
    if (both) chk("R9 stop_det cleared by start", stop_det, 0);
    if (extras) begin
      keep = buf_q;
      @(negedge clk);
      buf_wr = 1'b1;
      buf_wdata = ~keep;
      stop_req = 1'b1;
      @(negedge clk);
      buf_wr = 1'b0;
      stop_req = 1'b0;
      chk("R8 wcol set", wcol, 1);
      chk("R8 buffer kept", buf_q, keep);
      chk("R10 stop ignored while busy", stop_busy, 0);
    end
    wait_cyc(e + n + 1);
    repeat (s) @(negedge clk);
    stretch = 1'b0;
    wait_cyc(e + 2*n + 2 + s);
    if (!both) chk("R4 irq before end", irq, 0);
    chk("R3 still busy", ack_busy, 1);
    @(negedge clk);
    chk("R4 irq at end", irq, 1);
    chk("R4 ack busy cleared", ack_busy, 0);
    chk("R4 scl held in idle", scl_pull, 1);
  endtask

  task automatic do_stop(int n, int s);
    int e;
    reload = BAUD_W'(n);
    stop_req = 1'b1;
    stretch = 1'b1;
    e = cyc + 1;
    push(e, 1'b1, 1'b1, "R5");
    push(e + n + 2, 1'b0, 1'b1, "R5");
    push(e + 2*n + 4 + s, 1'b0, 1'b0, "R6");
    @(negedge clk);
    stop_req = 1'b0;
    chk("R5 stop busy", stop_busy, 1);
    wait_cyc(e + n + 2);
    repeat (s) @(negedge clk);
    stretch = 1'b0;
    wait_cyc(e + 2*n + 4 + s);
    chk("R7 stop_det before bus high", stop_det, 0);
    @(negedge clk);
    chk("R7 stop_det set", stop_det, 1);
    wait_cyc(e + 3*n + 5 + s);
    chk("R7 irq before end", irq, 0);
    chk("R7 still busy", stop_busy, 1);
    @(negedge clk);
    chk("R7 irq at end", irq, 1);
    chk("R7 stop busy cleared", stop_busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 scl_pull", scl_pull, 0);
    chk("R11 sda_pull", sda_pull, 0);
    chk("R11 flags", {irq, stop_det, wcol}, 0);
    chk("R11 busy", {ack_busy, stop_busy}, 0);
    chk("R11 buffer", buf_q, 0);

    // R8 idle write lands
    buf_wr = 1'b1;
    buf_wdata = 8'h3C;
    @(negedge clk);
    buf_wr = 1'b0;
    chk("R8 idle write", buf_q, 8'h3C);
    chk("R8 no collision in idle", wcol, 0);

    do_ack(1'b0, 3, 0, 1'b0, 1'b0);
    clear_flags();
    do_ack(1'b1, 2, 4, 1'b1, 1'b0);
    clear_flags();
    chk("R9 wcol cleared", wcol, 0);
    chk("R9 irq cleared", irq, 0);

    do_stop(3, 0);
    repeat (4) @(negedge clk);
    chk("R9 stop_det sticky", stop_det, 1);
    chk("R9 irq sticky", irq, 1);
    clear_flags();
    chk("R9 stop_det cleared", stop_det, 0);

    do_stop(0, 2);
    do_ack(1'b0, 1, 0, 1'b0, 1'b1);
    repeat (8) @(negedge clk);
    chk("R10 dropped stop never runs", stop_busy, 0);
    chk("R10 no pending events", exp_q.size(), 0);

    clear_flags();
    do_ack(1'b0, 40, 3, 1'b0, 1'b0);
    clear_flags();
    do_stop(5, 1);
    repeat (6) @(negedge clk);
    chk("R6 all events seen", exp_q.size(), 0);
    chk("R7 lines released", {scl_pull, sda_pull}, 0);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule